// File: doc/BRIEF.md
# Four-State Bitwise Logic Unit

This block evaluates bitwise logic on vectors whose bits carry four values: zero, one, high impedance (z) and unknown (x). Each bit travels as a two-bit code. The per-bit operations are AND, NAND, OR, NOR, XOR, XNOR, invert and blend. The OR and NOR reductions fold a whole vector into one four-state bit.

The truth tables favour a dominant value. A 0 decides an AND and a 1 decides an OR, even when the other side is unknown. A z is treated as an unknown wherever it enters a logic gate. Blend keeps a bit only when both inputs carry exactly the same code.

A reduction also writes its result back into a copy of the source vector, at a bit position chosen by the caller. The fold is computed from the whole source before that write, so the target bit may lie inside the vector being reduced. Both results are registered once and appear one clock after the operands are presented.

Top module: `fs_logic_unit`

## Requirements
- R1: Bit codes are 00 = 0, 01 = 1, 10 = z, 11 = x, and bit i of a vector occupies bits [2i+1:2i]. Operation code 0 is AND: a 0 on either side gives 0, 1 with 1 gives 1, and any other pair gives x.
- R2: Operation code 1 is NAND. It is the AND result inverted, with x staying x.
- R3: Operation code 2 is OR: a 1 on either side gives 1, 0 with 0 gives 0, and any other pair gives x.
- R4: Operation code 3 is NOR. It is the OR result inverted, with x staying x.
- R5: Operation codes 4 (XOR) and 5 (XNOR) follow the two-valued tables when both bits are 0 or 1, and give x when either bit is z or x.
- R6: Operation code 6 inverts operand A: 0 becomes 1, 1 becomes 0, and z or x becomes x. Operand B has no effect on this result.
- R7: Operation code 7 is blend. When both bits carry the same code, that code is output, including z and x. When they differ, the output is x.
- R8: Operation code 8 folds every bit of operand B with the OR rule into the scalar output. Operation code 9 outputs the inverse of that fold.
- R9: For codes 8 and 9, the vector output equals operand B with only bit pos_i replaced by the scalar result. The fold uses the original value of B, including the bit at pos_i.
- R10: For the per-bit operation codes 0 to 7, the scalar output is x (11).
- R11: Reserved codes 10 to 15 give an all-x vector and an x scalar.
- R12: Both outputs are registered. They show the result for the inputs present at the previous rising clock edge. An active-low asynchronous reset clears both outputs to all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| a_i | input | 2*W | Operand A, W encoded bits |
| b_i | input | 2*W | Operand B, W encoded bits; the source of reductions |
| pos_i | input | $clog2(W) | Bit position written by a reduction |
| y_o | output | 2*W | Vector result |
| r_o | output | 2 | Scalar reduction result |

## Verification
The reduction fold and the write-back into the vector output happen in the same cycle, and both read the same operand. The bench provokes the overlap by placing the written position on the one bit that decides the fold: a lone 1 among zeros, or a lone z among zeros. It then judges that the scalar reflects the original source, and that every other bit of the vector is passed through unchanged. Per-bit operations are driven over all sixteen code pairs, and each result is compared with a table model in a scoreboard queue.

// File: rtl/fs4_pkg.sv
package fs4_pkg;

    typedef logic [1:0] fs_t;

    localparam fs_t FS_0 = 2'b00;
    localparam fs_t FS_1 = 2'b01;
    localparam fs_t FS_Z = 2'b10;
    localparam fs_t FS_X = 2'b11;

    typedef enum logic [3:0] {
        OP_AND   = 4'd0,
        OP_NAND  = 4'd1,
        OP_OR    = 4'd2,
        OP_NOR   = 4'd3,
        OP_XOR   = 4'd4,
        OP_XNOR  = 4'd5,
        OP_INV   = 4'd6,
        OP_BLEND = 4'd7,
        OP_ORR   = 4'd8,
        OP_NORR  = 4'd9
    } op_e;

    // A code is a plain logic level when its upper bit is clear.
    function automatic logic fs_known(input fs_t v);
        return ~v[1];
    endfunction

    function automatic fs_t fs_not(input fs_t v);
        return fs_known(v) ? {1'b0, ~v[0]} : FS_X;
    endfunction

    function automatic fs_t fs_and(input fs_t l, input fs_t r);
        if (l == FS_0 || r == FS_0) return FS_0;
        if (l == FS_1 && r == FS_1) return FS_1;
        return FS_X;
    endfunction

    function automatic fs_t fs_or(input fs_t l, input fs_t r);
        if (l == FS_1 || r == FS_1) return FS_1;
        if (l == FS_0 && r == FS_0) return FS_0;
        return FS_X;
    endfunction

    function automatic fs_t fs_xor(input fs_t l, input fs_t r);
        if (fs_known(l) && fs_known(r)) return {1'b0, l[0] ^ r[0]};
        return FS_X;
    endfunction

    function automatic fs_t fs_blend(input fs_t l, input fs_t r);
        return (l == r) ? l : FS_X;
    endfunction

endpackage

// File: rtl/fs_lane.sv
module fs_lane
    import fs4_pkg::*;
(
    input  logic [3:0] op_i,
    input  fs_t        a_i,
    input  fs_t        b_i,
    output fs_t        y_o
);
    always_comb begin
        unique case (op_i)
            OP_AND:   y_o = fs_and(a_i, b_i);
            OP_NAND:  y_o = fs_not(fs_and(a_i, b_i));
            OP_OR:    y_o = fs_or(a_i, b_i);
            OP_NOR:   y_o = fs_not(fs_or(a_i, b_i));
            OP_XOR:   y_o = fs_xor(a_i, b_i);
            OP_XNOR:  y_o = fs_not(fs_xor(a_i, b_i));
            OP_INV:   y_o = fs_not(a_i);
            OP_BLEND: y_o = fs_blend(a_i, b_i);
            default:  y_o = FS_X;
        endcase
    end
endmodule

// File: rtl/fs_or_fold.sv
module fs_or_fold
    import fs4_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [2*W-1:0] src_i,
    output fs_t            fold_o
);
    always_comb begin
        fold_o = FS_0;
        for (int i = 0; i < W; i++) begin
            fold_o = fs_or(fold_o, src_i[2*i +: 2]);
        end
    end
endmodule

// File: rtl/fs_logic_unit.sv
module fs_logic_unit
    import fs4_pkg::*;
#(
    parameter int W = 8,
    localparam int PW = (W > 1) ? $clog2(W) : 1,
    localparam int VW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_i,
    input  logic [VW-1:0] a_i,
    input  logic [VW-1:0] b_i,
    input  logic [PW-1:0] pos_i,
    output logic [VW-1:0] y_o,
    output logic [1:0]    r_o
);
    typedef struct packed {
        logic [VW-1:0] vec;
        fs_t           red;
    } out_s;

    out_s out_d, out_q;

    logic [VW-1:0] lane_y;
    fs_t           fold;

    for (genvar g = 0; g < W; g++) begin : g_lane
        fs_lane u_lane (
            .op_i (op_i),
            .a_i  (a_i[2*g +: 2]),
            .b_i  (b_i[2*g +: 2]),
            .y_o  (lane_y[2*g +: 2])
        );
    end

    fs_or_fold #(.W(W)) u_fold (
        .src_i  (b_i),
        .fold_o (fold)
    );

    always_comb begin
        out_d = '0;
        if (op_i == OP_ORR || op_i == OP_NORR) begin
            out_d.red = (op_i == OP_NORR) ? fs_not(fold) : fold;
            out_d.vec = b_i;
            for (int i = 0; i < W; i++) begin
                if (PW'(i) == pos_i) out_d.vec[2*i +: 2] = out_d.red;
            end
        end else begin
            out_d.vec = lane_y;
            out_d.red = FS_X;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign y_o = out_q.vec;
    assign r_o = out_q.red;
endmodule

// File: rtl/fs_logic_unit_chk.sv
module fs_logic_unit_chk #(
    parameter int W = 8,
    localparam int PW = (W > 1) ? $clog2(W) : 1,
    localparam int VW = 2 * W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    op_i,
    input logic [VW-1:0] a_i,
    input logic [VW-1:0] b_i,
    input logic [PW-1:0] pos_i,
    input logic [VW-1:0] y_o,
    input logic [1:0]    r_o
);
    localparam logic [VW-1:0] ONES01 = {W{2'b01}};
    localparam logic [VW-1:0] LOW2   = VW'(2'b11);

    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R1: all-zero B forces AND to all zeros
    a_r1_and_zero_dominates: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_i) == 4'd0 && $past(b_i) == '0 |-> y_o == '0);

    // R3: all-one A forces OR to all ones
    a_r3_or_one_dominates: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_i) == 4'd2 && $past(a_i) == ONES01 |-> y_o == ONES01);

    // R7: identical operands pass through blend
    a_r7_blend_identical: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_i) == 4'd7 && $past(a_i) == $past(b_i) |-> y_o == $past(a_i));

    // R9: a reduction touches only the selected bit of the source copy
    a_r9_writeback_local: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ($past(op_i) == 4'd8 || $past(op_i) == 4'd9)
        |-> ((y_o ^ $past(b_i)) & ~(LOW2 << (2 * $past(pos_i)))) == '0);

    // R10: per-bit operations report an unknown scalar
    a_r10_scalar_idle: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_i) < 4'd8 |-> r_o == 2'b11);

    // R11: reserved codes give all unknowns
    a_r11_reserved_unknown: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_i) > 4'd9 |-> (y_o == '1 && r_o == 2'b11));
endmodule

bind fs_logic_unit fs_logic_unit_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .op_i  (op_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .pos_i (pos_i),
    .y_o   (y_o),
    .r_o   (r_o)
);

// File: tb/tb_fs_logic_unit.sv
module tb_fs_logic_unit;
    localparam int W  = 8;
    localparam int PW = 3;
    localparam int VW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    op_i = '0;
    logic [VW-1:0] a_i = '0;
    logic [VW-1:0] b_i = '0;
    logic [PW-1:0] pos_i = '0;
    logic [VW-1:0] y_o;
    logic [1:0]    r_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    typedef struct {
        logic [VW-1:0] y;
        logic [1:0]    r;
        string         tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    fs_logic_unit #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .pos_i(pos_i), .y_o(y_o), .r_o(r_o)
    );

    // Table model: 0=00 1=01 z=10 x=11
    function automatic logic [1:0] m_bit(input logic [3:0] op, input logic [1:0] a, input logic [1:0] b);
        logic az, bz, ao, bo, ak, bk;
        az = (a == 2'b00); bz = (b == 2'b00);
        ao = (a == 2'b01); bo = (b == 2'b01);
        ak = az | ao;      bk = bz | bo;
        case (op)
            4'd0: return (az | bz) ? 2'b00 : (ao & bo) ? 2'b01 : 2'b11;
            4'd1: return (az | bz) ? 2'b01 : (ao & bo) ? 2'b00 : 2'b11;
            4'd2: return (ao | bo) ? 2'b01 : (az & bz) ? 2'b00 : 2'b11;
            4'd3: return (ao | bo) ? 2'b00 : (az & bz) ? 2'b01 : 2'b11;
            4'd4: return (ak & bk) ? ((ao != bo) ? 2'b01 : 2'b00) : 2'b11;
            4'd5: return (ak & bk) ? ((ao == bo) ? 2'b01 : 2'b00) : 2'b11;
            4'd6: return az ? 2'b01 : ao ? 2'b00 : 2'b11;
            4'd7: return (a == b) ? a : 2'b11;
            default: return 2'b11;
        endcase
    endfunction

    task automatic drive(input logic [3:0] op, input logic [VW-1:0] a, input logic [VW-1:0] b,
                         input logic [PW-1:0] pos, input string tag);
        exp_t e;
        logic [1:0] fold;
        bit one, unk;
        e.tag = tag;
        if (op == 4'd8 || op == 4'd9) begin
            one = 0; unk = 0;
            for (int i = 0; i < W; i++) begin
                if (b[2*i +: 2] == 2'b01) one = 1;
                else if (b[2*i +: 2] != 2'b00) unk = 1;
            end
            fold = one ? 2'b01 : unk ? 2'b11 : 2'b00;
            if (op == 4'd9 && fold != 2'b11) fold = {1'b0, ~fold[0]};
            e.r = fold;
            e.y = b;
            e.y[2*pos +: 2] = fold;
        end else begin
            e.r = 2'b11;
            for (int i = 0; i < W; i++) e.y[2*i +: 2] = m_bit(op, a[2*i +: 2], b[2*i +: 2]);
        end
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; pos_i = pos;
        sb.push_back(e);
    endtask

    // Monitor: results appear one edge after drive (R12)
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rst_n && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (y_o !== e.y || r_o !== e.r) begin
                    n_err++;
                    $display("FAIL %s: got y=%h r=%b, expected y=%h r=%b", e.tag, y_o, r_o, e.y, e.r);
                end
            end
        end
    end

    function automatic logic [VW-1:0] all_of(input logic [1:0] c);
        return {W{c}};
    endfunction

    initial begin
        logic [VW-1:0] pa, pb;
        repeat (3) @(negedge clk);
        n_chk++;
        if (y_o !== '0 || r_o !== 2'b00) begin
            n_err++;
            $display("FAIL R12 reset: got y=%h r=%b, expected y=0 r=00", y_o, r_o);
        end
        rst_n = 1'b1;
        // All sixteen code pairs for each per-bit operation, two vectors of eight
        for (int op = 0; op < 8; op++) begin
            for (int h = 0; h < 2; h++) begin
                for (int k = 0; k < W; k++) begin
                    int idx = h * W + k;
                    pa[2*k +: 2] = 2'(idx / 4);
                    pb[2*k +: 2] = 2'(idx % 4);
                end
                case (op)
                    0: drive(4'(op), pa, pb, 0, "R1 and");
                    1: drive(4'(op), pa, pb, 0, "R2 nand");
                    2: drive(4'(op), pa, pb, 0, "R3 or");
                    3: drive(4'(op), pa, pb, 0, "R4 nor");
                    4: drive(4'(op), pa, pb, 0, "R5 xor");
                    5: drive(4'(op), pa, pb, 0, "R5 xnor");
                    6: drive(4'(op), pa, pb, 0, "R6 invert");
                    default: drive(4'(op), pa, pb, 0, "R7 blend");
                endcase
            end
        end
        // R6: B has no effect on invert
        drive(4'd6, 16'h1B4E, all_of(2'b11), 0, "R6 invert ignores B");
        // R7: identical z and x survive blend
        drive(4'd7, all_of(2'b10), all_of(2'b10), 0, "R7 blend z");
        // R10: scalar reads x after per-bit ops
        drive(4'd0, all_of(2'b01), all_of(2'b01), 0, "R10 scalar idle");
        // R8: reductions
        drive(4'd8, '0, all_of(2'b00), 3, "R8 or-reduce zeros");
        drive(4'd9, '0, all_of(2'b00), 3, "R8 nor-reduce zeros");
        drive(4'd8, '0, 16'hFFF7, 0, "R8 one among x");
        drive(4'd9, '0, 16'hAAA9, 7, "R8 nor one among z");
        drive(4'd8, '0, 16'h0020, 4, "R8 z gives x");
        // R9: destination on the deciding bit
        drive(4'd8, '0, 16'h0100, 4, "R9 overlap lone one");
        drive(4'd9, '0, 16'h0800, 5, "R9 overlap lone z");
        drive(4'd9, '0, 16'h4000, 0, "R9 far position");
        // R11: reserved codes
        drive(4'd10, 16'h5555, 16'h0000, 0, "R11 reserved 10");
        drive(4'd15, 16'h0000, 16'h5555, 2, "R11 reserved 15");
        @(negedge clk);
        @(negedge clk);
        // R12: asynchronous reset clears outputs
        rst_n = 1'b0;
        #2;
        n_chk++;
        if (y_o !== '0 || r_o !== 2'b00) begin
            n_err++;
            $display("FAIL R12 async reset: got y=%h r=%b, expected y=0 r=00", y_o, r_o);
        end
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout, expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule